// File: doc/BRIEF.md
# Serial Flash Command and Program/Erase Engine

This block sits behind a serial front-end that has already turned the wire traffic into whole bytes. Each transfer is framed by a select input. The block decodes the instruction in the first byte. It keeps a write-enable latch and a three-bit protection field, and it owns a small byte array that follows NOR flash rules. Programming can only clear bits, and only erasing sets them back to ones. Erasing works on one sector or on the whole array.

A page-program transfer first gathers up to one page of data bytes into a staging buffer. When the select input drops, an internal cycle runs, and the busy flag stays high for the whole of it. During that cycle a walker writes one byte per clock into the array. Erase and status-write cycles use the same timer. Their lengths are parameters counted in clock cycles, raised where needed so that the walker can cover its whole range. A read instruction streams array bytes back through a registered output. A status read returns the live status byte.

Top module: `flashcmd_top`

## Requirements
- R1: After reset the status byte is 00h, so busy, the write-enable latch and the protect field are all clear, and the array contents are undefined until the first erase.
- R2: The status byte holds busy in bit 0, the write-enable latch in bit 1 and the protect field in bits 4:2, and bits 7:5 read zero. A one-byte frame with opcode 06h sets the latch and one with 04h clears it. After the opcode of a 05h frame, the response byte carries the status byte.
- R3: A program, erase or status-write frame that arrives while the write-enable latch is clear is ignored. No cycle starts and the array is unchanged.
- R4: Page program is opcode 02h, then three address bytes with the most significant first, then the data bytes. Each addressed byte becomes its old value ANDed with the data, and bytes of the page that were not sent keep their value.
- R5: When more than one page of data follows, the column wraps within the same page, and only the last page-size bytes are applied.
- R6: Opcode D8h with three address bytes sets every byte of the addressed sector (2^SECT_W bytes) to FFh. The one-byte opcode C7h sets the whole array to FFh.
- R7: A protect value p greater than 0 locks the top min(2^(p-1), sector count) sectors. A program or sector erase aimed into a locked sector is ignored and leaves the write-enable latch set. Bulk erase is ignored whenever p is not 0.
- R8: Opcode 01h followed by one byte loads bits 4:2 of that byte into the protect field at the end of its cycle. The whole instruction is ignored while the write-protect input is low.
- R9: Busy is high for exactly the configured number of cycles after an accepted frame ends. The write-enable latch clears when the cycle completes. Write-type frames and WREN sent while busy are ignored, but status reads still work.
- R10: A frame whose end is flagged as not falling on a byte boundary executes nothing.
- R11: Opcode 03h with three address bytes puts the addressed byte on the response output two cycles after the last address byte. Each further received byte advances the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | High while a frame is in progress |
| rx_valid_i | input | 1 | One-cycle strobe for a received byte |
| rx_byte_i | input | 8 | Received byte |
| frag_i | input | 1 | Sampled as the frame ends: frame stopped between byte boundaries |
| wp_n_i | input | 1 | Write-protect, active low, blocks status writes |
| busy_o | output | 1 | Internal cycle in progress |
| status_o | output | 8 | Status byte |
| tx_byte_o | output | 8 | Registered response byte (status or read data) |

## Verification
A frame can end in the same cycle that an internal cycle is running. At that point two functions compete: the decoder's commit of a new instruction, and the engine's busy cycle, which still owns the array and the staging buffer. The bench provokes this by sending a write-enable and a page-program frame to a live sector while a long sector erase is running, and by reading status during the same window. It then judges that the sector reads back as all FFh, that the write-enable latch ends clear, and that the status read showed busy with the latch set.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;
  localparam logic [7:0] OPC_READ = 8'h03;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE
  } kind_e;

  // Top sectors locked by a protect value: 0 none, p -> 2^(p-1), capped.
  function automatic logic sect_locked(input logic [2:0] bp,
                                       input logic [31:0] sect,
                                       input logic [31:0] nsect);
    logic [31:0] n;
    n = (bp == 3'd0) ? 32'd0 : (32'd1 << (bp - 3'd1));
    if (n > nsect) n = nsect;
    return (sect + n) >= nsect;
  endfunction

endpackage

// File: rtl/flashcmd_decode.sv
module flashcmd_decode
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              frag_i,
  input  logic              busy_i,
  output logic              go_o,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        sr_byte_o,
  output logic              buf_clr_o,
  output logic              buf_we_o,
  output logic [PAGE_W-1:0] buf_col_o,
  output logic [7:0]        buf_data_o,
  output logic              rd_mode_o,
  output logic [ADDR_W-1:0] rd_ptr_o
);

  logic              sel_q;
  logic [2:0]        cnt;      // bytes received, saturates at 5
  logic [7:0]        opcode;
  logic [23:0]       addr24;
  logic [PAGE_W-1:0] data_n;
  logic              void_q;   // frame began while busy
  logic [7:0]        sr_byte;
  logic [ADDR_W-1:0] rd_ptr;
  logic              rx;

  assign rx = sel_i & rx_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      cnt     <= '0;
      opcode  <= '0;
      addr24  <= '0;
      data_n  <= '0;
      void_q  <= 1'b0;
      sr_byte <= '0;
      rd_ptr  <= '0;
    end else begin
      sel_q <= sel_i;
      if (!sel_i) begin
        cnt    <= '0;
        data_n <= '0;
        void_q <= 1'b0;
      end else if (rx) begin
        if (cnt != 3'd5) cnt <= cnt + 3'd1;
        if (cnt == 3'd0) begin
          opcode <= rx_byte_i;
          void_q <= busy_i;
        end else if (cnt <= 3'd3) begin
          addr24 <= {addr24[15:0], rx_byte_i};
          if (cnt == 3'd1) sr_byte <= rx_byte_i;
          if (cnt == 3'd3) rd_ptr <= ADDR_W'({addr24[15:0], rx_byte_i});
        end else begin
          data_n <= data_n + 1'b1;
          rd_ptr <= rd_ptr + 1'b1;
        end
      end
    end
  end

  kind_e kind;
  always_comb begin
    kind = K_NONE;
    case (opcode)
      OPC_WREN: if (cnt == 3'd1) kind = K_WREN;
      OPC_WRDI: if (cnt == 3'd1) kind = K_WRDI;
      OPC_WRSR: if (cnt == 3'd2) kind = K_WRSR;
      OPC_PP:   if (cnt == 3'd5) kind = K_PP;
      OPC_SE:   if (cnt == 3'd4) kind = K_SE;
      OPC_BE:   if (cnt == 3'd1) kind = K_BE;
      default:  kind = K_NONE;
    endcase
  end

  assign go_o       = sel_q & ~sel_i & ~frag_i & ~void_q & (kind != K_NONE);
  assign kind_o     = kind;
  assign addr_o     = addr24[ADDR_W-1:0];
  assign sr_byte_o  = sr_byte;
  assign buf_clr_o  = rx & (cnt == 3'd0) & (rx_byte_i == OPC_PP) & ~busy_i;
  assign buf_we_o   = rx & (cnt >= 3'd4) & (opcode == OPC_PP) & ~void_q & ~busy_i;
  assign buf_col_o  = addr24[PAGE_W-1:0] + data_n;
  assign buf_data_o = rx_byte_i;
  assign rd_mode_o  = (opcode == OPC_READ) & (cnt >= 3'd4);
  assign rd_ptr_o   = rd_ptr;

endmodule

// File: rtl/flashcmd_pagebuf.sv
module flashcmd_pagebuf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] col_i,
  input  logic [7:0]        data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_mask_o
);

  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0]        store [PAGE_N];
  logic [PAGE_N-1:0] mask;

  always_ff @(posedge clk) begin
    if (we_i) store[col_i] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) mask <= '0;
    else if (we_i)    mask[col_i] <= 1'b1;
  end

  assign rd_data_o = store[rd_idx_i];
  assign rd_mask_o = mask[rd_idx_i];

endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter int T_PP   = 300,
  parameter int T_SE   = 600,
  parameter int T_BE   = 2100,
  parameter int T_SR   = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n_i,
  input  logic              go_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_byte_i,
  input  logic              rd_mode_i,
  input  logic [ADDR_W-1:0] rd_ptr_i,
  input  logic [7:0]        buf_data_i,
  input  logic              buf_mask_i,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic              busy_o,
  output logic              wel_o,
  output logic [2:0]        bp_o,
  output logic [7:0]        tx_byte_o
);

  localparam int MEM_N  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int SECT_N = 1 << SECT_W;
  localparam int NSECT  = 1 << (ADDR_W - SECT_W);
  localparam int D_PP   = (T_PP > PAGE_N) ? T_PP : PAGE_N;
  localparam int D_SE   = (T_SE > SECT_N) ? T_SE : SECT_N;
  localparam int D_BE   = (T_BE > MEM_N)  ? T_BE : MEM_N;
  localparam int D_SR   = (T_SR > 0)      ? T_SR : 1;
  localparam int D_MAX  = (D_BE > D_SE) ? ((D_BE > D_PP) ? D_BE : D_PP)
                                        : ((D_SE > D_PP) ? D_SE : D_PP);
  localparam int TW     = $clog2(((D_MAX > D_SR) ? D_MAX : D_SR) + 1);
  localparam int IW     = ADDR_W + 1;

  logic [7:0]        mem [MEM_N];
  logic              busy, wel;
  logic [2:0]        bp;
  logic [TW-1:0]     timer;
  logic [IW-1:0]     idx;
  kind_e             cur;
  logic [ADDR_W-1:0] base;
  logic [7:0]        sr_new;
  logic [7:0]        status;

  assign status = {3'b000, bp, wel, busy};

  // Admission of a write-type frame
  logic locked, ok, start;
  assign locked = sect_locked(bp, 32'(addr_i[ADDR_W-1:SECT_W]), 32'(NSECT));
  always_comb begin
    case (kind_i)
      K_WRSR:      ok = wel & wp_n_i;
      K_PP, K_SE:  ok = wel & ~locked;
      K_BE:        ok = wel & (bp == 3'd0);
      default:     ok = 1'b0;
    endcase
  end
  assign start = go_i & ~busy & ok;

  // Walker: one array byte per busy cycle
  logic [IW-1:0]     span;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_en;
  logic [7:0]        wr_data;
  always_comb begin
    case (cur)
      K_PP: begin
        span    = IW'(PAGE_N);
        wr_addr = {base[ADDR_W-1:PAGE_W], idx[PAGE_W-1:0]};
      end
      K_SE: begin
        span    = IW'(SECT_N);
        wr_addr = {base[ADDR_W-1:SECT_W], idx[SECT_W-1:0]};
      end
      K_BE: begin
        span    = IW'(MEM_N);
        wr_addr = idx[ADDR_W-1:0];
      end
      default: begin
        span    = '0;
        wr_addr = idx[ADDR_W-1:0];
      end
    endcase
  end
  assign buf_idx_o = idx[PAGE_W-1:0];
  assign wr_en     = busy & (idx < span) & ((cur != K_PP) | buf_mask_i);
  assign wr_data   = (cur == K_PP) ? (mem[wr_addr] & buf_data_i) : 8'hFF;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      wel       <= 1'b0;
      bp        <= '0;
      timer     <= '0;
      idx       <= '0;
      cur       <= K_NONE;
      base      <= '0;
      sr_new    <= '0;
      tx_byte_o <= '0;
    end else begin
      tx_byte_o <= rd_mode_i ? mem[rd_ptr_i] : status;
      if (busy) begin
        if (idx != IW'(MEM_N)) idx <= idx + 1'b1;
        if (timer == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (cur == K_WRSR) bp <= sr_new[4:2];
        end else begin
          timer <= timer - 1'b1;
        end
      end else if (go_i) begin
        if (kind_i == K_WREN)      wel <= 1'b1;
        else if (kind_i == K_WRDI) wel <= 1'b0;
        else if (start) begin
          busy   <= 1'b1;
          idx    <= '0;
          cur    <= kind_i;
          base   <= addr_i;
          sr_new <= sr_byte_i;
          case (kind_i)
            K_PP:    timer <= TW'(D_PP - 1);
            K_SE:    timer <= TW'(D_SE - 1);
            K_BE:    timer <= TW'(D_BE - 1);
            default: timer <= TW'(D_SR - 1);
          endcase
        end
      end
    end
  end

  assign busy_o = busy;
  assign wel_o  = wel;
  assign bp_o   = bp;

endmodule

// File: rtl/flashcmd_top.sv
module flashcmd_top
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 9,
  parameter int T_PP   = 300,
  parameter int T_SE   = 600,
  parameter int T_BE   = 2100,
  parameter int T_SR   = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       frag_i,
  input  logic       wp_n_i,
  output logic       busy_o,
  output logic [7:0] status_o,
  output logic [7:0] tx_byte_o
);

  logic              go, buf_clr, buf_we, rd_mode, buf_mask, wel;
  kind_e             kind;
  logic [ADDR_W-1:0] addr, rd_ptr;
  logic [7:0]        sr_byte, buf_wdata, buf_rdata;
  logic [PAGE_W-1:0] buf_col, buf_idx;
  logic [2:0]        bp;

  flashcmd_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .clk(clk), .rst(rst), .sel_i(sel_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .frag_i(frag_i), .busy_i(busy_o),
    .go_o(go), .kind_o(kind), .addr_o(addr), .sr_byte_o(sr_byte),
    .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_col_o(buf_col),
    .buf_data_o(buf_wdata), .rd_mode_o(rd_mode), .rd_ptr_o(rd_ptr)
  );

  flashcmd_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .clr_i(buf_clr), .we_i(buf_we),
    .col_i(buf_col), .data_i(buf_wdata), .rd_idx_i(buf_idx),
    .rd_data_o(buf_rdata), .rd_mask_o(buf_mask)
  );

  flashcmd_engine #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
    .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_SR(T_SR)
  ) u_eng (
    .clk(clk), .rst(rst), .wp_n_i(wp_n_i), .go_i(go), .kind_i(kind),
    .addr_i(addr), .sr_byte_i(sr_byte), .rd_mode_i(rd_mode),
    .rd_ptr_i(rd_ptr), .buf_data_i(buf_rdata), .buf_mask_i(buf_mask),
    .buf_idx_o(buf_idx), .busy_o(busy_o), .wel_o(wel), .bp_o(bp),
    .tx_byte_o(tx_byte_o)
  );

  assign status_o = {3'b000, bp, wel, busy_o};

endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] status
);

  // R9: the latch is clear in the cycle busy drops
  p_wel_clear_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> !status[1]);

  // R8: protect field only moves when a cycle completes
  p_bp_only_at_done_r8: assert property (@(posedge clk) disable iff (rst)
    !$fell(status[0]) |-> $stable(status[4:2]));

  // R3: a cycle only starts with the latch set
  p_busy_needs_wel_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(status[1]));

  // R9: the latch cannot be set while busy
  p_wel_set_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> !$past(status[0]));

  // R2: unused status bits stay zero
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status[7:5] == 3'b000);

endmodule

bind flashcmd_top flashcmd_chk u_chk (.clk(clk), .rst(rst), .status(status_o));

// File: tb/flashcmd_top_bench.sv
module flashcmd_top_bench;

  localparam int MEM_N = 2048;
  localparam int T_SR  = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, rxv = 1'b0, frag = 1'b0, wp_n = 1'b1;
  logic [7:0] rxb = 8'h00;
  logic       busy;
  logic [7:0] status, tx;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] model [MEM_N];
  logic [7:0] frm [300];

  always #2.5 clk = ~clk;

  flashcmd_top #(.T_SR(T_SR)) u_flashcmd_top (
    .clk(clk), .rst(rst), .sel_i(sel), .rx_valid_i(rxv), .rx_byte_i(rxb),
    .frag_i(frag), .wp_n_i(wp_n), .busy_o(busy), .status_o(status),
    .tx_byte_o(tx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] b);
    rxv = 1'b1; rxb = b;
    @(negedge clk); rxv = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input int n, input bit fr);
    @(negedge clk); sel = 1'b1;
    for (int i = 0; i < n; i++) pulse(frm[i]);
    sel = 1'b0; frag = fr;
    @(negedge clk); frag = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] op);
    frm[0] = op; frame(1, 1'b0);
  endtask

  task automatic cmd_a(input logic [7:0] op, input int a, input int ndata, input bit fr);
    frm[0] = op; frm[1] = 8'(a >> 16); frm[2] = 8'(a >> 8); frm[3] = 8'(a);
    frame(4 + ndata, fr);
  endtask

  task automatic wrsr(input logic [7:0] v);
    frm[0] = 8'h01; frm[1] = v; frame(2, 1'b0);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic pp_model(input int a, input int ndata);
    logic [7:0] b [256];
    bit m [256];
    for (int i = 0; i < 256; i++) m[i] = 0;
    for (int i = 0; i < ndata; i++) begin
      b[(a + i) & 255] = frm[4 + i];
      m[(a + i) & 255] = 1;
    end
    for (int i = 0; i < 256; i++)
      if (m[i]) model[(a & ~255) | i] = model[(a & ~255) | i] & b[i];
  endtask

  task automatic read_chk(input int a, input int n, input string req);
    int bad = -1;
    logic [7:0] badv = 8'h00;
    @(negedge clk); sel = 1'b1;
    pulse(8'h03); pulse(8'(a >> 16)); pulse(8'(a >> 8)); pulse(8'(a));
    for (int i = 0; i < n; i++) begin
      if (bad < 0 && tx !== model[(a + i) % MEM_N]) begin bad = i; badv = tx; end
      pulse(8'h00);
    end
    sel = 1'b0;
    @(negedge clk);
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, int'(badv), int'(model[(a + bad) % MEM_N]));
  endtask

  task automatic t_reset;
    check(status == 8'h00, "R1 reset status", status, 8'h00);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
  endtask

  task automatic t_wel;
    cmd1(8'h06);
    check(status == 8'h02, "R2 WREN sets latch", status, 8'h02);
    @(negedge clk); sel = 1'b1; pulse(8'h05);
    check(tx == 8'h02, "R2 RDSR response", tx, 8'h02);
    sel = 1'b0; @(negedge clk);
    cmd1(8'h04);
    check(status == 8'h00, "R2 WRDI clears latch", status, 8'h00);
  endtask

  task automatic t_bulk;
    cmd1(8'h06); cmd1(8'hC7);
    check(busy == 1'b1, "R6 bulk erase starts", busy, 1);
    wait_idle;
    for (int i = 0; i < MEM_N; i++) model[i] = 8'hFF;
    check(status == 8'h00, "R9 latch cleared after erase", status, 8'h00);
    read_chk(0, MEM_N, "R6 R11 bulk erase all FF");
  endtask

  task automatic t_nowel;
    frm[4] = 8'h00;
    cmd_a(8'h02, 'h100, 1, 1'b0);
    check(busy == 1'b0, "R3 program without latch", busy, 0);
    read_chk('h100, 4, "R3 array unchanged");
  endtask

  task automatic t_pp;
    cmd1(8'h06);
    frm[4] = 8'hA5; frm[5] = 8'h3C; frm[6] = 8'hFF;
    cmd_a(8'h02, 'h105, 3, 1'b0); pp_model('h105, 3); wait_idle;
    cmd1(8'h06);
    frm[4] = 8'h0F;
    cmd_a(8'h02, 'h106, 1, 1'b0); pp_model('h106, 1); wait_idle;
    check(model['h106] == 8'h0C, "R4 model AND", model['h106], 8'h0C);
    read_chk('h100, 16, "R4 program ANDs data, rest of page kept");
  endtask

  task automatic t_wrap;
    cmd1(8'h06);
    for (int i = 0; i < 260; i++) frm[4 + i] = 8'(i) ^ 8'h5A;
    cmd_a(8'h02, 'h2F0, 260, 1'b0); pp_model('h2F0, 260); wait_idle;
    read_chk('h200, 256, "R5 column wrap keeps last page");
  endtask

  task automatic t_se;
    cmd1(8'h06); cmd_a(8'hD8, 'h250, 0, 1'b0); wait_idle;
    for (int i = 'h200; i < 'h400; i++) model[i] = 8'hFF;
    read_chk('h200, 512, "R6 sector erase");
    read_chk('h100, 16, "R6 other sector untouched");
  endtask

  task automatic t_busy;
    int n;
    cmd1(8'h06); cmd_a(8'hD8, 'h000, 0, 1'b0);
    @(negedge clk); sel = 1'b1; pulse(8'h05);
    check(tx == 8'h03, "R9 status read while busy", tx, 8'h03);
    sel = 1'b0; @(negedge clk);
    cmd1(8'h06);
    frm[4] = 8'h00; cmd_a(8'h02, 'h010, 1, 1'b0);
    wait_idle;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    check(status == 8'h00, "R9 latch cleared, nothing queued", status, 8'h00);
    read_chk('h000, 32, "R9 program during busy ignored");
    cmd1(8'h06); wrsr(8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == T_SR, "R9 busy length", n, T_SR);
  endtask

  task automatic t_prot;
    cmd1(8'h06); wrsr(8'h04); wait_idle;
    check(status == 8'h04, "R8 protect field loaded", status, 8'h04);
    cmd1(8'h06);
    frm[4] = 8'h00; cmd_a(8'h02, 'h600, 1, 1'b0);
    check(status == 8'h06, "R7 program into locked sector", status, 8'h06);
    cmd_a(8'hD8, 'h700, 0, 1'b0);
    cmd1(8'hC7);
    check(status == 8'h06, "R7 sector and bulk erase locked", status, 8'h06);
    frm[4] = 8'h55; cmd_a(8'h02, 'h010, 1, 1'b0); pp_model('h010, 1);
    check(busy == 1'b1, "R7 unlocked sector accepted", busy, 1);
    wait_idle;
    read_chk('h600, 16, "R7 locked data kept");
    read_chk('h010, 1, "R7 unlocked program");
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00);
    check(status == 8'h06, "R8 write-protect blocks status write", status, 8'h06);
    wp_n = 1'b1;
    wrsr(8'h08); wait_idle;
    check(status == 8'h08, "R8 protect value 2", status, 8'h08);
    cmd1(8'h06); cmd_a(8'hD8, 'h400, 0, 1'b0);
    check(status == 8'h0A, "R7 two top sectors locked", status, 8'h0A);
    wrsr(8'h00); wait_idle;
    check(status == 8'h00, "R8 protect cleared", status, 8'h00);
  endtask

  task automatic t_frag;
    frm[0] = 8'h06; frame(1, 1'b1);
    check(status == 8'h00, "R10 fragmented WREN", status, 8'h00);
    cmd1(8'h06);
    frm[4] = 8'h00; cmd_a(8'h02, 'h020, 1, 1'b1);
    check(status == 8'h02, "R10 fragmented program", status, 8'h02);
    read_chk('h020, 2, "R10 array unchanged");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset; t_wel; t_bulk; t_nowel; t_pp; t_wrap; t_se; t_busy; t_prot; t_frag;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule